// File: doc/BRIEF.md
# Port Status Register Bank with Current-Limit Power Gating

This block holds the most recent detection outcome and classification outcome for each of four powered network ports. At the end of a detection phase the measurement logic presents a 3-bit result code for a port together with a one-cycle capture strobe. The classification phase does the same with its own code and strobe. Each port's two codes are combined into one byte. Software reads that byte at one of four consecutive addresses.

The same stored codes also gate power-on. A per-port power request passes straight through to a permit output unless the protection enable is set and that port's stored class code reports a current-limit condition. In that case the permit is withheld.

For convenience, the bank also decodes each port's stored codes into three flags: a valid-signature flag, a class-valid flag and a plain class number.

Top module: `psr_port_status`

## Requirements
- R1: After a synchronous active-low reset every port's status byte reads 8'h00.
- R2: A detection strobe for port i at a clock edge loads that port's 3-bit detection code into bits [2:0] of its byte. The class field and the other ports are unchanged, and the field holds its value while no strobe arrives.
- R3: A classification strobe for port i at a clock edge loads that port's 3-bit class code into bits [6:4] of its byte. The detection field and the other ports are unchanged, and the field holds its value while no strobe arrives.
- R4: The read data is combinational from the read address. Address BASE_ADDR+i (default 0x0C..0x0F) returns port i's byte with bits 3 and 7 at 0. Any other address returns 8'h00.
- R5: With the protection enable at 0, each port's permit equals its request.
- R6: With the protection enable at 1, a port whose stored class code is 3'b111 has its permit at 0 whatever its request.
- R7: With the protection enable at 1, a port whose stored class code is not 3'b111 has its permit equal to its request.
- R8: A port's signature flag is 1 exactly when its stored detection code is 3'b100. All other detection codes give 0: 001/111 (DC supply), 010 (high capacitance), 011/101 (resistance out of range), 110 (open) and 000 (unknown).
- R9: A port's class number decodes 001, 010, 011 and 100 to 1, 2, 3 and 4, and decodes 101 and 110 to 0, with the class-valid flag at 1 for all six. Codes 000 and 111 give class-valid 0 and class number 0.
- R10: A detection strobe and a classification strobe for the same port at the same edge update both fields at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_wr | input | NPORT | Per-port detection capture strobe |
| det_code | input | 3*NPORT | Detection codes, port i at [3i+2:3i] |
| cls_wr | input | NPORT | Per-port classification capture strobe |
| cls_code | input | 3*NPORT | Class codes, port i at [3i+2:3i] |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Status byte at rd_addr |
| prot_en | input | 1 | Blocks power-on for current-limit class |
| pwr_req | input | NPORT | Per-port power-on request |
| pwr_permit | output | NPORT | Per-port power-on permit |
| sig_ok | output | NPORT | Stored detection code is a valid signature |
| cls_valid | output | NPORT | Stored class code is a real class |
| cls_num | output | 3*NPORT | Decoded class number per port |

## Verification
Directed writes of all eight detection and eight class codes to each port give the first coverage. Each write is followed by a read of that port's address. This separates field placement, cross-port leakage and decode errors. A long pseudo-random phase then drives independent strobes, codes, requests, protection toggles and address sweeps. The sweep includes addresses just outside the window and aliases that differ only in the high bits, so it exposes partial address compares. It also exposes permit logic that keys on the incoming code instead of the stored one. A reset in mid-run and simultaneous strobes on one port separate reset clearing from field-update ordering.

// File: rtl/psr_pkg.sv
// Package: shared code type, code values and byte packing for the port
// status bank. Assumes 3-bit result codes and an 8-bit status byte.
package psr_pkg;
    localparam int CODE_W = 3;
    localparam int BYTE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t DET_SIG_OK = 3'b100;
    localparam code_t CLS_NONE   = 3'b000;
    localparam code_t CLS_UNDEF  = 3'b101;
    localparam code_t CLS_ZERO   = 3'b110;
    localparam code_t CLS_ILIM   = 3'b111;

    // Place class in [6:4], detection in [2:0]; bits 3 and 7 stay zero.
    function automatic logic [BYTE_W-1:0] pack_status(code_t det, code_t cls);
        return {1'b0, cls, 1'b0, det};
    endfunction
endpackage

// File: rtl/psr_slot.sv
// Module: one port's result storage. Holds the detection and class codes,
// each loaded by its own strobe. Assumes strobes are single-cycle and
// synchronous to clk.
module psr_slot
    import psr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  det_we,
    input  code_t det_in,
    input  logic  cls_we,
    input  code_t cls_in,
    output code_t det_q,
    output code_t cls_q
);

    // Capture the detection result at the end of its phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      det_q <= '0;
        else if (det_we) det_q <= det_in;
    end

    // Capture the classification result at the end of its phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      cls_q <= '0;
        else if (cls_we) cls_q <= cls_in;
    end

    a_r2_det_load: assert property (@(posedge clk) disable iff (!rst_n)
        det_we |=> det_q == $past(det_in));
    a_r2_det_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !det_we |=> $stable(det_q));
    a_r3_cls_load: assert property (@(posedge clk) disable iff (!rst_n)
        cls_we |=> cls_q == $past(cls_in));
    a_r3_cls_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_we |=> $stable(cls_q));

endmodule

// File: rtl/psr_decode.sv
// Module: per-port decode of stored codes into a signature flag, a class
// number and a power-on permit. Purely combinational; assumes the codes
// come from registers so the permit never follows an incoming code.
module psr_decode
    import psr_pkg::*;
(
    input  code_t       det_q,
    input  code_t       cls_q,
    input  logic        prot_en,
    input  logic        req,
    output logic        sig_ok,
    output logic        cls_valid,
    output logic [2:0]  cls_num,
    output logic        permit
);

    logic ilim;

    // Flag a valid signature and a current-limit class.
    always_comb begin
        sig_ok = (det_q == DET_SIG_OK);
        ilim   = (cls_q == CLS_ILIM);
    end

    // Map class codes to class numbers; undefined folds into class 0.
    always_comb begin
        cls_valid = 1'b1;
        cls_num   = 3'd0;
        unique case (cls_q)
            3'b001:              cls_num = 3'd1;
            3'b010:              cls_num = 3'd2;
            3'b011:              cls_num = 3'd3;
            3'b100:              cls_num = 3'd4;
            CLS_UNDEF, CLS_ZERO: cls_num = 3'd0;
            default:             cls_valid = 1'b0;
        endcase
    end

    // Pass the request unless protection blocks a current-limit port.
    always_comb permit = req && !(prot_en && ilim);

    // R9: class number never leaves 0..4 and is 0 whenever not valid.
    always_comb begin
        a_r9_num_range: assert (cls_num <= 3'd4);
        a_r9_invalid_zero: assert (cls_valid || cls_num == 3'd0);
    end

endmodule

// File: rtl/psr_read_mux.sv
// Module: address decode and read-data select over the status bytes.
// Assumes BASE_ADDR+NPORT-1 fits in AW bits; every other address reads 0.
module psr_read_mux #(
    parameter int          NPORT     = 4,
    parameter int          AW        = 8,
    parameter int unsigned BASE_ADDR = 12
) (
    input  logic [AW-1:0]               addr,
    input  logic [NPORT-1:0][7:0]       bytes_in,
    output logic [7:0]                  data
);

    logic [NPORT-1:0] hit;

    // One exact comparator per slot address.
    for (genvar i = 0; i < NPORT; i++) begin : g_hit
        assign hit[i] = (addr == AW'(BASE_ADDR + i));
    end

    // OR together the bytes of the selected slot.
    always_comb begin
        data = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (hit[i]) data = data | bytes_in[i];
        end
    end

    // R4: at most one slot answers any address.
    always_comb a_r4_one_hit: assert ($onehot0(hit));

endmodule

// File: rtl/psr_port_status.sv
// Module: top of the port status bank. Per port it stores the detection
// and class codes, reads them back as one byte at consecutive addresses,
// decodes them and gates power-on requests. Assumes a synchronous
// active-low reset and single-cycle capture strobes.
module psr_port_status
    import psr_pkg::*;
#(
    parameter int          NPORT     = 4,
    parameter int          AW        = 8,
    parameter int unsigned BASE_ADDR = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORT-1:0]     det_wr,
    input  logic [3*NPORT-1:0]   det_code,
    input  logic [NPORT-1:0]     cls_wr,
    input  logic [3*NPORT-1:0]   cls_code,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 prot_en,
    input  logic [NPORT-1:0]     pwr_req,
    output logic [NPORT-1:0]     pwr_permit,
    output logic [NPORT-1:0]     sig_ok,
    output logic [NPORT-1:0]     cls_valid,
    output logic [3*NPORT-1:0]   cls_num
);

    code_t                 det_q [NPORT];
    code_t                 cls_q [NPORT];
    logic [NPORT-1:0][7:0] status_byte;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        psr_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .det_we (det_wr[i]),
            .det_in (det_code[CODE_W*i +: CODE_W]),
            .cls_we (cls_wr[i]),
            .cls_in (cls_code[CODE_W*i +: CODE_W]),
            .det_q  (det_q[i]),
            .cls_q  (cls_q[i])
        );

        psr_decode u_dec (
            .det_q     (det_q[i]),
            .cls_q     (cls_q[i]),
            .prot_en   (prot_en),
            .req       (pwr_req[i]),
            .sig_ok    (sig_ok[i]),
            .cls_valid (cls_valid[i]),
            .cls_num   (cls_num[CODE_W*i +: CODE_W]),
            .permit    (pwr_permit[i])
        );

        // Form the readable byte from the two stored fields.
        assign status_byte[i] = pack_status(det_q[i], cls_q[i]);

        a_r6_ilim_block: assert property (@(posedge clk) disable iff (!rst_n)
            (prot_en && cls_q[i] == CLS_ILIM) |-> !pwr_permit[i]);
        a_r5_pass_open: assert property (@(posedge clk) disable iff (!rst_n)
            !prot_en |-> pwr_permit[i] == pwr_req[i]);
        a_r10_both_load: assert property (@(posedge clk) disable iff (!rst_n)
            (det_wr[i] && cls_wr[i]) |=> status_byte[i] ==
            pack_status($past(det_code[CODE_W*i +: CODE_W]),
                        $past(cls_code[CODE_W*i +: CODE_W])));
    end

    psr_read_mux #(
        .NPORT     (NPORT),
        .AW        (AW),
        .BASE_ADDR (BASE_ADDR)
    ) u_rd (
        .addr     (rd_addr),
        .bytes_in (status_byte),
        .data     (rd_data)
    );

    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] == 1'b0 && rd_data[7] == 1'b0);

endmodule

// File: tb/test_psr_port_status.sv
module test_psr_port_status;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] det_wr = '0, cls_wr = '0, pwr_req = '0;
    logic [3*NP-1:0] det_code = '0, cls_code = '0;
    logic [7:0]    rd_addr = '0;
    logic          prot_en = 1'b0;
    logic [7:0]    rd_data;
    logic [NP-1:0] pwr_permit, sig_ok, cls_valid;
    logic [3*NP-1:0] cls_num;

    int errors = 0, checks = 0;
    bit done = 0;
    int m_det [NP];
    int m_cls [NP];

    always #4 clk = ~clk;

    psr_port_status i_psr_port_status (
        .clk(clk), .rst_n(rst_n), .det_wr(det_wr), .det_code(det_code),
        .cls_wr(cls_wr), .cls_code(cls_code), .rd_addr(rd_addr),
        .rd_data(rd_data), .prot_en(prot_en), .pwr_req(pwr_req),
        .pwr_permit(pwr_permit), .sig_ok(sig_ok), .cls_valid(cls_valid),
        .cls_num(cls_num));

    // Reference model state: updated on each rising edge from the inputs.
    always @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (!rst_n) begin
                m_det[i] = 0; m_cls[i] = 0;
            end else begin
                if (det_wr[i]) m_det[i] = int'(det_code[3*i +: 3]);
                if (cls_wr[i]) m_cls[i] = int'(cls_code[3*i +: 3]);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_byte(int a);
        if (a >= 12 && a <= 15) return m_cls[a-12] * 16 + m_det[a-12];
        return 0;
    endfunction

    function automatic int exp_num(int c);
        case (c)
            1: return 1; 2: return 2; 3: return 3; 4: return 4;
            default: return 0;
        endcase
    endfunction

    // Compare every output against the model.
    task automatic compare_all();
        check((rd_addr >= 12 && rd_addr <= 15) ? "R2/R3/R4" : "R4",
              int'(rd_data), exp_byte(int'(rd_addr)));
        for (int i = 0; i < NP; i++) begin
            string pr;
            pr = !prot_en ? "R5" : (m_cls[i] == 7 ? "R6" : "R7");
            check(pr, int'(pwr_permit[i]),
                  (prot_en && m_cls[i] == 7) ? 0 : int'(pwr_req[i]));
            check("R8", int'(sig_ok[i]), m_det[i] == 4 ? 1 : 0);
            check("R9 valid", int'(cls_valid[i]),
                  (m_cls[i] >= 1 && m_cls[i] <= 6) ? 1 : 0);
            check("R9 num", int'(cls_num[3*i +: 3]), exp_num(m_cls[i]));
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1 compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all bytes zero after reset
        for (int a = 12; a < 16; a++) begin
            rd_addr = 8'(a); #1;
            check("R1", int'(rd_data), 0);
        end
        // Directed: every code to every port, separate strobes
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                det_wr = '0; cls_wr = '0;
                det_wr[p] = 1'b1; det_code[3*p +: 3] = 3'(c);
                rd_addr = 8'(12 + p);
                #1 compare_all();
                @(negedge clk);
                det_wr = '0; cls_wr[p] = 1'b1; cls_code[3*p +: 3] = 3'(7 - c);
                prot_en = 1'b1; pwr_req = '1;
                #1 compare_all();
                @(negedge clk);
                cls_wr = '0;
                #1 compare_all();
            end
        end
        // R10: both strobes on port 2 in one cycle
        @(negedge clk);
        det_wr = 4'b0100; cls_wr = 4'b0100;
        det_code[8:6] = 3'b100; cls_code[8:6] = 3'b011; rd_addr = 8'h0E;
        @(negedge clk);
        det_wr = '0; cls_wr = '0;
        #1 check("R10", int'(rd_data), 8'h34);
        // Pseudo-random phase with address sweep and one mid-run reset
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            det_wr = 4'($urandom); cls_wr = 4'($urandom);
            det_code = 12'($urandom); cls_code = 12'($urandom);
            pwr_req = 4'($urandom);
            if (n % 37 == 0) prot_en = ~prot_en;
            case (n % 8)
                0: rd_addr = 8'h0B; 1: rd_addr = 8'h10;
                2: rd_addr = 8'h8C; 3: rd_addr = 8'(n);
                default: rd_addr = 8'(12 + (n % 4));
            endcase
            rst_n = (n != 1500);
            #1 compare_all();
        end
        rst_n = 1'b1; det_wr = '0; cls_wr = '0;
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule